// File: doc/BRIEF.md
# Linked-List DMA Element Walker

This block is a single-channel list walker that sits between a memory holding transfer descriptors and a data mover. Software writes a chain of 24-byte elements into a dedicated region, each naming a source address, a destination address, a byte count and a control word. It then pulses `go`. The walker reads the elements one by one over a 64-bit memory read port and hands each copy job to the data mover. It waits for the mover to finish before it moves on to the next element.

A one-bit cycle flag lets software reuse the same region for chunk after chunk. An element is taken only when its cycle bit equals the walker's expected value. A link element ends the chunk and flips the expected value, so the old contents of the region read as stale until software writes them again. A stale element parks the walker without raising an interrupt. Another `go` resumes at that same element. Completion pulses are raised per element through two enable bits. A mover error or an overrun into the reserved last slot raises an abort instead.

Top module: `ll_dma_walker`

## Requirements
- R1: After reset, `exp_cycle` is 1, `busy` and `stalled` are 0, and no memory read, copy request or pulse is raised.
- R2: An element takes three consecutive 64-bit words. Word 0 holds the control word in bits 31:0 and the length in bits 63:32. Word 1 is the source and word 2 is the destination. Elements sit back to back, and a `go` from idle starts at `cfg_base`, which is 8-byte aligned.
- R3: A length field of 1 to 2^32-1 is handed to the mover unchanged on the 33-bit `cp_len`. A length field of 0 stands for 2^32 bytes.
- R4: An element whose control bit 0 differs from `exp_cycle` is not consumed. The walker sets `stalled` with no pulse and no copy. A later `go` refetches that same element, ignoring `cfg_base`.
- R5: A link element has control bit 1 set and a matching cycle bit. It ends the list with no copy, returns the walker to idle and inverts `exp_cycle`.
- R6: When the mover reports completion, `done_lcl` pulses for one cycle if control bit 3 is set, and `done_rmt` pulses if control bit 4 is set.
- R7: At most one element is in flight. `cp_req` stays high with stable fields until `cp_done` or `cp_err`, and no memory read is issued while a copy is requested.
- R8: On `cp_err`, `abort` pulses, no done pulse is raised, the walker goes idle and `exp_cycle` is left unchanged.
- R9: A region of `REGION_BYTES` holds REGION_BYTES/24 - 1 data elements. A data element found at that 0-based slot index, which is kept for the link, raises `abort` without a copy.
- R10: `cfg_cyc_wr` loads `exp_cycle` from `cfg_cyc_val` only while the walker is idle or stalled. While busy it has no effect.
- R11: A stale or link element costs a single memory read. A data element costs three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Byte address of the list region |
| cfg_cyc_wr | input | 1 | Load strobe for the expected cycle bit |
| cfg_cyc_val | input | 1 | Value loaded into the expected cycle bit |
| go | input | 1 | Start from idle, or resume from stalled |
| exp_cycle | output | 1 | Current expected cycle bit |
| busy | output | 1 | Walker is fetching or copying |
| stalled | output | 1 | Parked on a stale element |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_rd_addr | output | AW | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 64 | Read data word |
| cp_req | output | 1 | Copy request, held until done or error |
| cp_src | output | 64 | Copy source address |
| cp_dst | output | 64 | Copy destination address |
| cp_len | output | 33 | Copy byte count |
| cp_done | input | 1 | Mover finished the copy |
| cp_err | input | 1 | Mover failed the copy |
| done_lcl | output | 1 | Local completion pulse |
| done_rmt | output | 1 | Remote completion pulse |
| abort | output | 1 | Abort pulse |

## Verification
The hardest state to reach is a stall in the middle of a list followed by a resume. Reaching it needs one valid element consumed first, then a stale one. The stimulus writes a chunk whose second element carries the wrong cycle bit. It then rewrites only that element, moves `cfg_base` to a different region and pulses `go`. The resumed copy must carry the rewritten source, which proves the pointer was held. Overrunning the reserved slot needs a region filled completely with valid data elements and no link, which the bench builds directly.

// File: rtl/ll_dma_walker.sv
module ll_dma_walker #(
  parameter int AW           = 16,
  parameter int REGION_BYTES = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic          cfg_cyc_wr,
  input  logic          cfg_cyc_val,
  input  logic          go,
  output logic          exp_cycle,
  output logic          busy,
  output logic          stalled,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_valid,
  input  logic [63:0]   mem_rd_data,
  output logic          cp_req,
  output logic [63:0]   cp_src,
  output logic [63:0]   cp_dst,
  output logic [32:0]   cp_len,
  input  logic          cp_done,
  input  logic          cp_err,
  output logic          done_lcl,
  output logic          done_rmt,
  output logic          abort
);
  localparam int ELEM_BYTES = 24;
  localparam int MAX_DATA   = REGION_BYTES / ELEM_BYTES - 1;
  localparam int SW         = $clog2(MAX_DATA + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_COPY, S_STALL} st_t;

  st_t           st;
  logic [AW-1:0] ptr;
  logic [SW-1:0] slot;
  logic [1:0]    widx;
  logic [31:0]   len_q;
  logic          lie_q, rie_q;

  assign mem_rd_en   = (st == S_REQ);
  assign mem_rd_addr = ptr + AW'({widx, 3'b000});
  assign cp_req      = (st == S_COPY);
  assign cp_len      = (len_q == 32'd0) ? 33'h1_0000_0000 : {1'b0, len_q};
  assign busy        = (st != S_IDLE) && (st != S_STALL);
  assign stalled     = (st == S_STALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      exp_cycle <= 1'b1;
      ptr       <= '0;
      slot      <= '0;
      widx      <= '0;
      len_q     <= '0;
      lie_q     <= 1'b0;
      rie_q     <= 1'b0;
      cp_src    <= '0;
      cp_dst    <= '0;
      done_lcl  <= 1'b0;
      done_rmt  <= 1'b0;
      abort     <= 1'b0;
    end else begin
      done_lcl <= 1'b0;
      done_rmt <= 1'b0;
      abort    <= 1'b0;
      case (st)
        S_IDLE, S_STALL: begin
          if (cfg_cyc_wr) exp_cycle <= cfg_cyc_val;
          if (go) begin
            widx <= '0;
            st   <= S_REQ;
            if (st == S_IDLE) begin
              ptr  <= cfg_base;
              slot <= '0;
            end
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (mem_rd_valid) begin
            case (widx)
              2'd0: begin
                len_q <= mem_rd_data[63:32];
                lie_q <= mem_rd_data[3];
                rie_q <= mem_rd_data[4];
                if (mem_rd_data[0] != exp_cycle) begin
                  st <= S_STALL;
                end else if (mem_rd_data[1]) begin
                  exp_cycle <= ~exp_cycle;
                  st        <= S_IDLE;
                end else if (slot == SW'(MAX_DATA)) begin
                  abort <= 1'b1;
                  st    <= S_IDLE;
                end else begin
                  widx <= 2'd1;
                  st   <= S_REQ;
                end
              end
              2'd1: begin
                cp_src <= mem_rd_data;
                widx   <= 2'd2;
                st     <= S_REQ;
              end
              default: begin
                cp_dst <= mem_rd_data;
                st     <= S_COPY;
              end
            endcase
          end
        end
        S_COPY: begin
          if (cp_err) begin
            abort <= 1'b1;
            st    <= S_IDLE;
          end else if (cp_done) begin
            done_lcl <= lie_q;
            done_rmt <= rie_q;
            ptr      <= ptr + AW'(ELEM_BYTES);
            slot     <= slot + 1'b1;
            widx     <= '0;
            st       <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ll_dma_walker_chk.sv
module ll_dma_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_cyc_wr,
  input logic        exp_cycle,
  input logic        busy,
  input logic        stalled,
  input logic        mem_rd_en,
  input logic        mem_rd_valid,
  input logic        cp_req,
  input logic [63:0] cp_src,
  input logic [63:0] cp_dst,
  input logic [32:0] cp_len,
  input logic        cp_done,
  input logic        cp_err,
  input logic        done_lcl,
  input logic        done_rmt,
  input logic        abort
);
  AST_NO_READ_DURING_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_req && mem_rd_en)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_req && !cp_done && !cp_err) |=> (cp_req && $stable(cp_src) && $stable(cp_dst) && $stable(cp_len))); // R7
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_lcl || done_rmt) |-> $past(cp_done && cp_req)); // R6
  AST_ABORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!done_lcl && !done_rmt && !busy)); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> (!cp_req && !mem_rd_en && !done_lcl && !done_rmt && !abort)); // R4
  AST_CYCLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exp_cycle) |-> ($past(cfg_cyc_wr && !busy) || $past(mem_rd_valid))); // R10
endmodule

bind ll_dma_walker ll_dma_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cyc_wr(cfg_cyc_wr), .exp_cycle(exp_cycle),
  .busy(busy), .stalled(stalled), .mem_rd_en(mem_rd_en), .mem_rd_valid(mem_rd_valid),
  .cp_req(cp_req), .cp_src(cp_src), .cp_dst(cp_dst), .cp_len(cp_len),
  .cp_done(cp_done), .cp_err(cp_err), .done_lcl(done_lcl), .done_rmt(done_rmt),
  .abort(abort)
);

// File: tb/ll_dma_walker_tb.sv
module ll_dma_walker_tb;
  localparam int AW = 16;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] len;
    logic [63:0] src;
    logic [63:0] dst;
  } elem_t;

  localparam elem_t TAB [5] = '{
    '{32'h01, 32'h0000_0001, 64'h0000_0000_0000_1000, 64'h0000_0000_0000_2000},
    '{32'h09, 32'h0000_0040, 64'hAAAA_0000_0000_0040, 64'h5555_0000_0000_0080},
    '{32'h01, 32'h0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0002_0000_0000},
    '{32'h11, 32'h0000_1234, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321},
    '{32'h19, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0008}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic cfg_cyc_wr = 1'b0, cfg_cyc_val = 1'b0, go = 1'b0;
  logic exp_cycle, busy, stalled, mem_rd_en, cp_req;
  logic [AW-1:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic [63:0] cp_src, cp_dst;
  logic [32:0] cp_len;
  logic cp_done = 1'b0, cp_err = 1'b0;
  logic done_lcl, done_rmt, abort;

  always #2.5 clk = ~clk;

  ll_dma_walker #(.AW(AW), .REGION_BYTES(240)) u_dut (.*);

  logic [63:0] mem [128];
  logic [63:0] lg_src [64];
  logic [63:0] lg_dst [64];
  logic [32:0] lg_len [64];
  int n_cp = 0, n_rd = 0, n_lcl = 0, n_rmt = 0, n_abt = 0, n_ovl = 0;
  int n_chk = 0, n_bad = 0;
  logic err_mode = 1'b0;
  logic pend = 1'b0, mv_busy = 1'b0, finished = 1'b0;
  logic [AW-1:0] paddr = '0;
  int mv_cnt = 0;

  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (pend) begin
      mem_rd_valid = 1'b1;
      mem_rd_data  = mem[paddr >> 3];
      pend = 1'b0;
    end
    if (mem_rd_en) begin
      pend  = 1'b1;
      paddr = mem_rd_addr;
      n_rd++;
      if (cp_req || mv_busy) n_ovl++;
    end
  end

  always @(negedge clk) begin
    cp_done = 1'b0;
    cp_err  = 1'b0;
    if (mv_busy) begin
      if (mv_cnt == 0) begin
        if (err_mode) cp_err = 1'b1;
        else begin
          cp_done = 1'b1;
          lg_src[n_cp] = cp_src;
          lg_dst[n_cp] = cp_dst;
          lg_len[n_cp] = cp_len;
          n_cp++;
        end
        mv_busy = 1'b0;
      end else mv_cnt--;
    end else if (cp_req) begin
      mv_busy = 1'b1;
      mv_cnt  = 2;
    end
  end

  always @(negedge clk) begin
    if (done_lcl) n_lcl++;
    if (done_rmt) n_rmt++;
    if (abort) n_abt++;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int base, input int slot, input logic [31:0] ctrl,
                     input logic [31:0] len, input logic [63:0] src, input logic [63:0] dst);
    int w = base / 8 + slot * 3;
    mem[w]     = {len, ctrl};
    mem[w + 1] = src;
    mem[w + 2] = dst;
  endtask

  task automatic pulse_go();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int c0, r0, l0, m0, a0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 exp_cycle", 64'(exp_cycle), 64'd1);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 stalled", 64'(stalled), 64'd0);
    check("R1 requests", 64'({mem_rd_en, cp_req, done_lcl, done_rmt, abort}), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R5 R6 R11: table-driven chunk at base 0
    for (int i = 0; i < 5; i++) put(0, i, TAB[i].ctrl, TAB[i].len, TAB[i].src, TAB[i].dst);
    put(0, 5, 32'h3, 32'h0, 64'h0, 64'h0);
    c0 = n_cp; r0 = n_rd; l0 = n_lcl; m0 = n_rmt;
    cfg_base = 16'h0000;
    pulse_go();
    settle();
    check("R2 copy count", 64'(n_cp - c0), 64'd5);
    for (int i = 0; i < 5; i++) begin
      check("R2 source", lg_src[c0 + i], TAB[i].src);
      check("R2 destination", lg_dst[c0 + i], TAB[i].dst);
      check("R3 length", 64'(lg_len[c0 + i]),
            (TAB[i].len == 0) ? 64'h1_0000_0000 : 64'(TAB[i].len));
    end
    check("R6 local pulses", 64'(n_lcl - l0), 64'd2);
    check("R6 remote pulses", 64'(n_rmt - m0), 64'd2);
    check("R5 cycle inverted", 64'(exp_cycle), 64'd0);
    check("R5 idle after link", 64'({busy, stalled}), 64'd0);
    check("R11 reads per chunk", 64'(n_rd - r0), 64'd16);

    // R4 R11: stale region rerun stalls on one read
    c0 = n_cp; r0 = n_rd; l0 = n_lcl; a0 = n_abt;
    pulse_go();
    settle();
    check("R4 stalled", 64'(stalled), 64'd1);
    check("R4 no copy", 64'(n_cp - c0), 64'd0);
    check("R4 no pulse", 64'((n_lcl - l0) + (n_abt - a0)), 64'd0);
    check("R11 stale read", 64'(n_rd - r0), 64'd1);

    // R4 R5: refill with cycle 0, resume ignores new base
    put(0, 0, 32'h0, 32'h8, 64'h3000, 64'h4000);
    put(0, 1, 32'h2, 32'h0, 64'h0, 64'h0);
    cfg_base = 16'h0100;
    c0 = n_cp;
    pulse_go();
    settle();
    check("R4 resume count", 64'(n_cp - c0), 64'd1);
    check("R4 resume source", lg_src[c0], 64'h3000);
    check("R5 cycle back", 64'(exp_cycle), 64'd1);

    // R4: stall mid-list, resume at same slot
    put(0, 0, 32'h1, 32'h10, 64'h5000, 64'h6000);
    put(0, 1, 32'h0, 32'h20, 64'h5100, 64'h6100);
    put(0, 2, 32'h3, 32'h0, 64'h0, 64'h0);
    cfg_base = 16'h0000;
    c0 = n_cp;
    pulse_go();
    settle();
    check("R4 mid stall", 64'(stalled), 64'd1);
    check("R4 before stall", 64'(n_cp - c0), 64'd1);
    put(0, 1, 32'h1, 32'h20, 64'h5180, 64'h6180);
    cfg_base = 16'h0100;
    pulse_go();
    settle();
    check("R4 resumed slot", lg_src[c0 + 1], 64'h5180);
    check("R4 resume done", 64'({busy, stalled, exp_cycle}), 64'd0);

    // R10: write in idle
    @(negedge clk) begin cfg_cyc_wr = 1'b1; cfg_cyc_val = 1'b1; end
    @(negedge clk) cfg_cyc_wr = 1'b0;
    check("R10 idle write", 64'(exp_cycle), 64'd1);

    // R8: mover error
    put(256, 0, 32'h19, 32'h4, 64'h7000, 64'h8000);
    err_mode = 1'b1;
    l0 = n_lcl; m0 = n_rmt; a0 = n_abt;
    cfg_base = 16'h0100;
    pulse_go();
    settle();
    err_mode = 1'b0;
    check("R8 abort pulse", 64'(n_abt - a0), 64'd1);
    check("R8 no done", 64'((n_lcl - l0) + (n_rmt - m0)), 64'd0);
    check("R8 idle", 64'({busy, stalled}), 64'd0);
    check("R8 cycle kept", 64'(exp_cycle), 64'd1);

    // R10: write ignored while busy
    put(256, 0, 32'h1, 32'h4, 64'h7100, 64'h8100);
    put(256, 1, 32'h3, 32'h0, 64'h0, 64'h0);
    pulse_go();
    while (!cp_req) @(negedge clk);
    cfg_cyc_wr = 1'b1; cfg_cyc_val = 1'b0;
    @(negedge clk) cfg_cyc_wr = 1'b0;
    check("R10 busy write ignored", 64'(exp_cycle), 64'd1);
    settle();
    check("R10 link after ignore", 64'(exp_cycle), 64'd0);
    @(negedge clk) begin cfg_cyc_wr = 1'b1; cfg_cyc_val = 1'b1; end
    @(negedge clk) cfg_cyc_wr = 1'b0;
    check("R10 restore", 64'(exp_cycle), 64'd1);

    // R9: full region with no link overruns the reserved slot
    for (int s = 0; s < 10; s++) put(0, s, 32'h1, 32'h4, 64'(s), 64'(s + 100));
    cfg_base = 16'h0000;
    c0 = n_cp; a0 = n_abt;
    pulse_go();
    settle();
    check("R9 copies", 64'(n_cp - c0), 64'd9);
    check("R9 abort", 64'(n_abt - a0), 64'd1);
    check("R9 last source", lg_src[c0 + 8], 64'd8);
    check("R9 cycle kept", 64'(exp_cycle), 64'd1);

    check("R7 no overlap", 64'(n_ovl), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule